// File: doc/BRIEF.md
# Per-Timeslot Transmit Payload Conditioner

This block sits in a transmit path that has already turned the serial payload into bytes, one byte per channel (timeslot). Each byte arrives with a strobe, its channel index and a marker on the first channel of a frame. The block can replace the byte with a substitute. The substitute is a programmable trunk code, a repeating eight-byte milliwatt tone or a byte from a loopback source. The block can also overwrite the byte with bits from an external test-pattern source. Last, it can invert selected bit positions. It emits the conditioned byte one clock later with its own strobe.

The controls come in two levels. A global substitution selector applies to every channel. A per-channel table gives each channel its own substitution code and a test flag. A master enable switches all processing off. A mode input picks either 24 channels or 32 timeslots per frame. Channel indices past the active count are passed through untouched.

Top module: `tpc_conditioner`

## Requirements
- R1: While `ctl_enable` is 0, every strobed byte appears on `out_byte` unchanged, whatever the other controls hold.
- R2: A nonzero `global_sub` applies to all in-range channels and overrides the per-channel table. The codes are: 1 means trunk code (`trunk_code`), 2 means milliwatt byte, 3 means `loop_byte`, and 4 to 7 mean no replacement.
- R3: When `global_sub` is 0, each channel uses the substitution code in bits [2:0] of its 4-bit table entry. The codes are the same as in R2. The entry of channel n sits at `cfg_table[4n+3:4n]`.
- R4: The milliwatt byte is taken from the sequence 1E, 0B, 0B, 1E, 9E, 8B, 8B, 9E (hex), indexed by a 3-bit phase. After reset the phase is 7. It advances by one, modulo 8, on every strobe that carries `frame_start`, and that strobe already uses the new value. All channels of one frame therefore share one entry, and the first frame after reset uses entry 0.
- R5: Test insertion is active when `test_en` is 1 and `test_dir` is 0. With `test_mode` 00 (unframed), every in-range byte becomes `prbs_byte` and the per-channel test flag is ignored.
- R6: With `test_mode` 01, a channel whose test flag (entry bit 3) is set gets all eight bits from `prbs_byte`. With 10, such a channel takes bits [7:1] from `prbs_byte` and keeps bit 0 of the substituted byte. Mode 11, and `test_dir` 1, leave the byte as it was.
- R7: On a channel where both apply, test insertion overrides substitution, because it acts on the result of substitution.
- R8: Inversion is applied last. `inv_msb` flips bit 7, `inv_even` flips bits 0, 2, 4 and 6, and `inv_odd` flips bits 1, 3, 5 and 7. The enabled masks are ORed, so a bit is flipped at most once.
- R9: With `e1_mode` 0 only channels 0 to 23 are processed, and bytes on indices 24 and above leave unchanged. With `e1_mode` 1, channels 0 to 31 are processed.
- R10: `out_valid` pulses exactly one clock after each `in_valid`. `out_byte` holds its value between strobes. After reset, `out_valid` and `out_byte` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_enable | input | 1 | Master enable for all conditioning |
| e1_mode | input | 1 | 1: 32 timeslots, 0: 24 channels |
| global_sub | input | 3 | Global substitution code, 0 = use table |
| trunk_code | input | 8 | Programmable trunk code byte |
| test_en | input | 1 | Test-pattern function enable |
| test_dir | input | 1 | 0: insert pattern, 1: extract only (no change) |
| test_mode | input | 2 | 00 unframed, 01 8-bit, 10 7-bit, 11 none |
| inv_msb | input | 1 | Invert bit 7 |
| inv_even | input | 1 | Invert even bit positions |
| inv_odd | input | 1 | Invert odd bit positions |
| cfg_table | input | NCH_E1*4 | Per-channel entries: [3] test flag, [2:0] substitution |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Channel byte |
| in_chan | input | CHW | Channel index |
| frame_start | input | 1 | Marks the first channel of a frame |
| prbs_byte | input | 8 | Test-pattern byte |
| loop_byte | input | 8 | Payload loopback byte |
| out_valid | output | 1 | Output strobe |
| out_byte | output | 8 | Conditioned byte |

## Verification
The bench aims at the precedence points. It runs with a global code and a mixed table at the same time, so a block that let the table win would emit table-coded bytes. It sets test flags on substituted channels, so a block that ran test insertion before substitution would emit trunk or loopback bytes. It runs whole frames of milliwatt substitution across several frame starts, so a phase advanced per channel, or advanced one strobe late, shows up as a shifted tone byte. The 7-bit mode is checked for keeping bit 0. Channels 24 to 31 in 24-channel mode catch a block that processes past the active count. All eight inversion combinations catch a mask applied twice or in the wrong place.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

    localparam int CFGW = 4;

    localparam logic [2:0] SUB_NONE  = 3'd0;
    localparam logic [2:0] SUB_TRUNK = 3'd1;
    localparam logic [2:0] SUB_MW    = 3'd2;
    localparam logic [2:0] SUB_LOOP  = 3'd3;

    typedef enum logic [1:0] {
        TM_UNFRAMED = 2'b00,
        TM_OCTET    = 2'b01,
        TM_SEPTET   = 2'b10,
        TM_NONE     = 2'b11
    } tmode_e;

    typedef struct packed {
        logic       test;
        logic [2:0] sub;
    } chan_cfg_t;

    function automatic logic [7:0] mw_byte(input logic [2:0] idx);
        logic [7:0] v;
        case (idx)
            3'd0, 3'd3: v = 8'h1E;
            3'd1, 3'd2: v = 8'h0B;
            3'd4, 3'd7: v = 8'h9E;
            default:    v = 8'h8B;
        endcase
        return v;
    endfunction

    function automatic logic [7:0] inv_mask(input logic msb, input logic even, input logic odd);
        logic [7:0] m;
        m = 8'h00;
        if (even) m = m | 8'h55;
        if (odd)  m = m | 8'hAA;
        if (msb)  m[7] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/tpc_cfg_sel.sv
module tpc_cfg_sel
    import tpc_pkg::*;
#(
    parameter int NCH_E1 = 32,
    parameter int NCH_T1 = 24,
    parameter int CHW    = 5
) (
    input  logic [NCH_E1*CFGW-1:0] cfg_table,
    input  logic [CHW-1:0]         chan,
    input  logic                   e1_mode,
    input  logic [2:0]             global_sub,
    output logic                   in_range,
    output logic [2:0]             sub_sel,
    output logic                   test_flag
);
    chan_cfg_t tbl [NCH_E1];
    chan_cfg_t entry;

    for (genvar g = 0; g < NCH_E1; g++) begin : g_unpack
        assign tbl[g] = chan_cfg_t'(cfg_table[g*CFGW +: CFGW]);
    end

    always_comb begin
        in_range = e1_mode ? (int'(chan) < NCH_E1) : (int'(chan) < NCH_T1);
        entry    = in_range ? tbl[chan] : '0;
        sub_sel  = (global_sub != SUB_NONE) ? global_sub : entry.sub;
        test_flag = entry.test;
    end
endmodule

// File: rtl/tpc_subst.sv
module tpc_subst
    import tpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       strobe,
    input  logic       frame_start,
    input  logic [2:0] sel,
    input  logic [7:0] trunk_code,
    input  logic [7:0] loop_byte,
    input  logic [7:0] data_in,
    output logic [7:0] data_out
);
    logic [2:0] phase_q;
    logic [2:0] phase_eff;

    assign phase_eff = frame_start ? phase_q + 3'd1 : phase_q;

    always_ff @(posedge clk) begin
        if (rst)         phase_q <= 3'd7;
        else if (strobe) phase_q <= phase_eff;
    end

    always_comb begin
        case (sel)
            SUB_TRUNK: data_out = trunk_code;
            SUB_MW:    data_out = mw_byte(phase_eff);
            SUB_LOOP:  data_out = loop_byte;
            default:   data_out = data_in;
        endcase
    end

    // R4: the phase never moves on a strobe without a frame marker
    assert_phase_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (strobe && !frame_start) |=> $stable(phase_q));
endmodule

// File: rtl/tpc_test_ins.sv
module tpc_test_ins
    import tpc_pkg::*;
(
    input  logic       active,
    input  logic [1:0] mode,
    input  logic       flag,
    input  logic [7:0] pattern,
    input  logic [7:0] data_in,
    output logic [7:0] data_out
);
    tmode_e m;
    assign m = tmode_e'(mode);

    always_comb begin
        data_out = data_in;
        if (active) begin
            case (m)
                TM_UNFRAMED: data_out = pattern;
                TM_OCTET:    if (flag) data_out = pattern;
                TM_SEPTET:   if (flag) data_out = {pattern[7:1], data_in[0]};
                default:     data_out = data_in;
            endcase
        end
    end
endmodule

// File: rtl/tpc_invert.sv
module tpc_invert
    import tpc_pkg::*;
(
    input  logic       inv_msb,
    input  logic       inv_even,
    input  logic       inv_odd,
    input  logic [7:0] data_in,
    output logic [7:0] data_out
);
    assign data_out = data_in ^ inv_mask(inv_msb, inv_even, inv_odd);
endmodule

// File: rtl/tpc_conditioner.sv
module tpc_conditioner
    import tpc_pkg::*;
#(
    parameter int NCH_E1 = 32,
    parameter int NCH_T1 = 24,
    parameter int CHW    = $clog2(NCH_E1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ctl_enable,
    input  logic                   e1_mode,
    input  logic [2:0]             global_sub,
    input  logic [7:0]             trunk_code,
    input  logic                   test_en,
    input  logic                   test_dir,
    input  logic [1:0]             test_mode,
    input  logic                   inv_msb,
    input  logic                   inv_even,
    input  logic                   inv_odd,
    input  logic [NCH_E1*CFGW-1:0] cfg_table,
    input  logic                   in_valid,
    input  logic [7:0]             in_byte,
    input  logic [CHW-1:0]         in_chan,
    input  logic                   frame_start,
    input  logic [7:0]             prbs_byte,
    input  logic [7:0]             loop_byte,
    output logic                   out_valid,
    output logic [7:0]             out_byte
);
    logic       in_range;
    logic [2:0] sub_sel;
    logic       test_flag;
    logic       test_active;
    logic [7:0] subst_out;
    logic [7:0] test_out;
    logic [7:0] inv_out;
    logic [7:0] final_byte;

    tpc_cfg_sel #(.NCH_E1(NCH_E1), .NCH_T1(NCH_T1), .CHW(CHW)) i_cfg (
        .cfg_table (cfg_table),
        .chan      (in_chan),
        .e1_mode   (e1_mode),
        .global_sub(global_sub),
        .in_range  (in_range),
        .sub_sel   (sub_sel),
        .test_flag (test_flag)
    );

    tpc_subst i_subst (
        .clk        (clk),
        .rst        (rst),
        .strobe     (in_valid),
        .frame_start(frame_start),
        .sel        (sub_sel),
        .trunk_code (trunk_code),
        .loop_byte  (loop_byte),
        .data_in    (in_byte),
        .data_out   (subst_out)
    );

    assign test_active = test_en && !test_dir;

    tpc_test_ins i_test (
        .active  (test_active),
        .mode    (test_mode),
        .flag    (test_flag),
        .pattern (prbs_byte),
        .data_in (subst_out),
        .data_out(test_out)
    );

    tpc_invert i_inv (
        .inv_msb (inv_msb),
        .inv_even(inv_even),
        .inv_odd (inv_odd),
        .data_in (test_out),
        .data_out(inv_out)
    );

    assign final_byte = (ctl_enable && in_range) ? inv_out : in_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_byte  <= 8'h00;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_byte <= final_byte;
        end
    end

    assert_strobe_lat_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_strobe_src_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_byte));

    assert_bypass_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ctl_enable) |=> (out_byte == $past(in_byte)));

    assert_t1_range_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !e1_mode && (int'(in_chan) >= NCH_T1)) |=> (out_byte == $past(in_byte)));

    assert_unframed_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && test_active && (test_mode == TM_UNFRAMED)) |-> (test_out == prbs_byte));

    assert_septet_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && test_active && test_flag && (test_mode == TM_SEPTET))
        |-> (test_out == {prbs_byte[7:1], subst_out[0]}));
endmodule

// File: tb/test_tpc_conditioner.sv
`timescale 1ns/1ps
module test_tpc_conditioner;
    localparam int NCH = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic       en = 0, e1 = 1, ten = 0, tdir = 0, imsb = 0, ieven = 0, iodd = 0;
    logic [2:0] gsub = 0;
    logic [7:0] trunk = 8'hD5;
    logic [1:0] tmode = 0;
    logic [NCH*4-1:0] cfg_table;
    logic       in_valid = 0, frame_start = 0;
    logic [7:0] in_byte = 0, prbs_byte = 0, loop_byte = 0;
    logic [4:0] in_chan = 0;
    logic       out_valid;
    logic [7:0] out_byte;

    logic [3:0] cfg_mem [NCH];
    always_comb for (int i = 0; i < NCH; i++) cfg_table[i*4 +: 4] = cfg_mem[i];

    tpc_conditioner i_tpc_conditioner (
        .clk(clk), .rst(rst), .ctl_enable(en), .e1_mode(e1), .global_sub(gsub),
        .trunk_code(trunk), .test_en(ten), .test_dir(tdir), .test_mode(tmode),
        .inv_msb(imsb), .inv_even(ieven), .inv_odd(iodd), .cfg_table(cfg_table),
        .in_valid(in_valid), .in_byte(in_byte), .in_chan(in_chan),
        .frame_start(frame_start), .prbs_byte(prbs_byte), .loop_byte(loop_byte),
        .out_valid(out_valid), .out_byte(out_byte)
    );

    int checks = 0, errors = 0;
    int mph = 7;
    bit pend_v = 0;
    logic [7:0] pend_b = 8'h00;
    string pend_tag = "R10";
    logic [7:0] mw_ref [8] = '{8'h1E, 8'h0B, 8'h0B, 8'h1E, 8'h9E, 8'h8B, 8'h8B, 8'h9E};

    function automatic logic [7:0] model(input logic [7:0] b, input int ch,
                                         input logic [7:0] pat, input logic [7:0] lp, input int ph);
        int lim;
        int s;
        logic [7:0] r;
        bit flag;
        lim = e1 ? 32 : 24;
        if (!en || ch >= lim) return b;
        s = (gsub != 0) ? int'(gsub) : int'(cfg_mem[ch][2:0]);
        flag = cfg_mem[ch][3];
        r = b;
        if (s == 1) r = trunk;
        else if (s == 2) r = mw_ref[ph];
        else if (s == 3) r = lp;
        if (ten && !tdir) begin
            if (tmode == 2'b00) r = pat;
            else if (tmode == 2'b01 && flag) r = pat;
            else if (tmode == 2'b10 && flag) r = {pat[7:1], r[0]};
        end
        for (int k = 0; k < 8; k++)
            if ((imsb && k == 7) || (ieven && k % 2 == 0) || (iodd && k % 2 == 1)) r[k] = ~r[k];
        return r;
    endfunction

    task automatic verify();
        checks++;
        if (out_valid !== pend_v || out_byte !== pend_b) begin
            errors++;
            $display("FAIL %s: out_valid=%0b out_byte=%02h expected valid=%0b byte=%02h",
                     pend_tag, out_valid, out_byte, pend_v, pend_b);
        end
    endtask

    task automatic step(input bit v, input logic [7:0] b, input int ch, input bit fs, input string tag);
        @(negedge clk);
        verify();
        in_valid = v;
        in_byte = b;
        in_chan = ch[4:0];
        frame_start = fs;
        prbs_byte = 8'($urandom);
        loop_byte = 8'($urandom);
        pend_v = v;
        pend_tag = tag;
        if (v) begin
            if (fs) mph = (mph + 1) % 8;
            pend_b = model(b, ch, prbs_byte, loop_byte, mph);
        end
    endtask

    task automatic idle();
        step(0, 8'h00, 0, 0, "R10");
    endtask

    task automatic frame(input int n, input string tag);
        for (int ch = 0; ch < n; ch++) step(1, 8'($urandom), ch, ch == 0, tag);
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NCH; i++) cfg_mem[i] = 4'h0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R10: reset state checked by the first verify
        idle();
        // R1: disabled block passes data although every function is set
        gsub = 3'd1; ten = 1; imsb = 1; ieven = 1;
        frame(32, "R1");
        idle();
        en = 1; ten = 0; imsb = 0; ieven = 0;
        for (int i = 0; i < NCH; i++) cfg_mem[i] = 4'(i % 4);
        // R2: global selector overrides the mixed table
        gsub = 3'd1; frame(32, "R2");
        idle(); gsub = 3'd3; frame(32, "R2");
        idle(); gsub = 3'd5; frame(32, "R2");
        // R3: per-channel codes
        idle(); gsub = 3'd0; frame(32, "R3");
        step(0, 8'h00, 0, 0, "R10");
        frame(32, "R3");
        // R4: milliwatt phase across frames, gaps between frames
        idle(); gsub = 3'd2;
        for (int f = 0; f < 10; f++) begin
            frame(32, "R4");
            if (f % 3 == 0) idle();
        end
        // R5: unframed insertion ignores flags; R7 with trunk underneath
        idle(); gsub = 3'd1; ten = 1; tdir = 0; tmode = 2'b00;
        for (int i = 0; i < NCH; i++) cfg_mem[i] = {1'b0, 3'(i % 4)};
        frame(32, "R5");
        // R6 / R7: flagged channels in 8-bit and 7-bit modes
        idle();
        for (int i = 0; i < NCH; i++) cfg_mem[i] = {1'(i % 3 == 0), 3'(i % 4)};
        gsub = 3'd0; tmode = 2'b01; frame(32, "R6");
        idle(); gsub = 3'd1; frame(32, "R7");
        idle(); tmode = 2'b10; frame(32, "R6");
        idle(); gsub = 3'd3; frame(32, "R7");
        idle(); tmode = 2'b11; frame(32, "R6");
        idle(); tmode = 2'b00; tdir = 1; frame(32, "R6");
        // R8: all inversion combinations
        for (int m = 0; m < 8; m++) begin
            idle();
            imsb = m[0]; ieven = m[1]; iodd = m[2];
            ten = m[0]; tdir = 0; tmode = 2'b10; gsub = 3'd0;
            frame(32, "R8");
        end
        // R9: 24-channel mode with indices past the count
        idle(); e1 = 0; imsb = 1; gsub = 3'd1; ten = 0;
        frame(32, "R9");
        idle(); e1 = 1; frame(32, "R9");
        // R10: sparse strobes
        for (int i = 0; i < 20; i++) begin
            step(1, 8'($urandom), i, i == 0, "R10");
            idle();
            idle();
        end
        idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule